// File: doc/BRIEF.md
# Quadrature Position Counter Core

This block counts motion from one incremental encoder channel. It takes the two phase inputs and the index input from outside, brings them into the system clock domain, and filters them. It then turns their edges into up and down count steps in one of four count functions: pulse with direction, and quadrature decoding at one, two or four counts per cycle. A 24-bit count register follows the step stream under one of four limit policies. Two of these policies use the preset value as a ceiling.

Two toggle flags record wrap-arounds. The borrow flag flips on underflow and the carry flag flips on overflow, and their XOR serves as a 25th count bit. A direction flag records whether the last accepted step went up or down. A noise flag records any sample in which both quadrature phases changed together. The host writes mode fields, the preset, strobes and the filter divider directly as inputs. An edge of the index input can reload the count from the preset. In synchronous index operation that reload also requires both phases to be low.

Top module: `quad_count_core`

## Requirements
- R1: While and after reset, with no stimulus, count is 0 and borrow_tog, carry_tog, up_flag, noise_err and idx_sync are all 0.
- R2: With func_sel = 0 (pulse/direction), each rising edge of the filtered in_a is one step, up when in_b is 1 and down when in_b is 0. Falling edges of in_a and edges of in_b alone do not step.
- R3: With func_sel = 1, 2 or 3 (x1, x2, x4) and the forward phase order (in_a,in_b) = 00, 10, 11, 01: x1 steps only on in_a edges taken while in_b is 0 (rise = up, fall = down); x2 steps on every in_a edge; x4 steps on every in_a and in_b edge.
- R4: In a quadrature function, a filtered sample in which in_a and in_b both changed produces no step and sets noise_err. Under func_sel = 0 such a sample never sets noise_err.
- R5: With limit_mode = 0 (free-running), an up step from 0xFFFFFF gives 0 and toggles carry_tog, and a down step from 0 gives 0xFFFFFF and toggles borrow_tog.
- R6: With limit_mode = 1 (clamp), an up step at or above preset leaves the count unchanged, a down step at 0 leaves it at 0, and neither toggles a flag.
- R7: With limit_mode = 2 (one-shot), a wrap behaves as in R5 and then freezes the count against all steps until clear_strobe, load_strobe or an index load.
- R8: With limit_mode = 3 (modulo), an up step at or above preset gives 0 and toggles carry_tog, and a down step at 0 gives preset and toggles borrow_tog.
- R9: up_flag takes the direction (1 = up) of every step that count_en and the freeze of R7 allow, including steps that are held at a limit.
- R10: clear_strobe sets the count to 0 and takes priority over load_strobe. load_strobe copies preset into the count. flag_clear clears borrow_tog, carry_tog and noise_err.
- R11: While count_en is 0, phase edges change neither the count nor up_flag.
- R12: With idx_preset_en = 1, the active edge of the filtered in_idx loads preset into the count; idx_pol = 1 selects the rising edge and idx_pol = 0 the falling edge. With idx_preset_en = 0, index edges have no effect.
- R13: idx_sync is 1 exactly when idx_sync_req is 1 and func_sel is not 0. While idx_sync is 1, an index load happens only if the filtered in_a and in_b are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| func_sel | input | 2 | Count function: 0 pulse/dir, 1 x1, 2 x2, 3 x4 |
| limit_mode | input | 2 | Limit policy: 0 free, 1 clamp, 2 one-shot, 3 modulo |
| preset | input | 24 | Preset value and ceiling |
| count_en | input | 1 | Enables phase counting |
| load_strobe | input | 1 | One-cycle load of preset into count |
| clear_strobe | input | 1 | One-cycle clear of count |
| flag_clear | input | 1 | One-cycle clear of borrow, carry and noise flags |
| idx_preset_en | input | 1 | Enables preset load on index edge |
| idx_pol | input | 1 | Index active edge: 1 rising, 0 falling |
| idx_sync_req | input | 1 | Requests synchronous index qualification |
| filt_div | input | 8 | Filter sample tick every filt_div+1 clocks |
| in_a | input | 1 | Encoder phase A (asynchronous) |
| in_b | input | 1 | Encoder phase B (asynchronous) |
| in_idx | input | 1 | Encoder index (asynchronous) |
| count | output | 24 | Live count |
| borrow_tog | output | 1 | Toggles on each underflow wrap |
| carry_tog | output | 1 | Toggles on each overflow wrap |
| up_flag | output | 1 | Direction of last accepted step |
| noise_err | output | 1 | Sticky illegal-transition flag |
| idx_sync | output | 1 | Synchronous index mode in effect |

## Verification
Random single-phase toggles sent through each of the four count functions separate the decoders. x1 ignores in_b edges and half of the in_a edges, x2 ignores only in_b edges, and pulse/direction steps only on rising in_a. Directed walks past 0 and past the ceiling under each limit policy separate wrap, clamp, freeze and modulo behaviour. Simultaneous double toggles separate the noise path from a legal step. Index edges of both polarities, taken with the phases low and not low, separate the polarity choice from the synchronous qualification.

// File: rtl/qc_pkg.sv
package qc_pkg;
  typedef enum logic [1:0] {
    FN_PULSE_DIR = 2'd0,
    FN_QX1       = 2'd1,
    FN_QX2       = 2'd2,
    FN_QX4       = 2'd3
  } qc_func_e;

  typedef enum logic [1:0] {
    LM_FREE    = 2'd0,
    LM_CLAMP   = 2'd1,
    LM_ONESHOT = 2'd2,
    LM_MODULO  = 2'd3
  } qc_limit_e;
endpackage

// File: rtl/qc_deglitch.sv
// Two-flop synchroniser per input, then a filter that accepts a new level
// only after two consecutive divided sample ticks agree.
module qc_deglitch #(
  parameter int NUM   = 3,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  input  logic [NUM-1:0]   raw,
  output logic [NUM-1:0]   clean
);
  logic [DIV_W-1:0] tcnt;
  logic             tick;

  assign tick = (tcnt >= div);

  always_ff @(posedge clk) begin
    if (rst)       tcnt <= '0;
    else if (tick) tcnt <= '0;
    else           tcnt <= tcnt + 1'b1;
  end

  for (genvar g = 0; g < NUM; g++) begin : g_lane
    logic [1:0] sync_q;
    logic       samp_q;
    logic       out_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '0;
        samp_q <= 1'b0;
        out_q  <= 1'b0;
      end else begin
        sync_q <= {sync_q[0], raw[g]};
        if (tick) begin
          samp_q <= sync_q[1];
          if (samp_q == sync_q[1]) out_q <= sync_q[1];
        end
      end
    end
    assign clean[g] = out_q;
  end
endmodule

// File: rtl/qc_edge_decode.sv
// Turns filtered phase levels into registered step/direction/illegal pulses.
module qc_edge_decode
  import qc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] func,
  input  logic       a,
  input  logic       b,
  output logic       step,
  output logic       up,
  output logic       illegal
);
  qc_func_e fn;
  logic     pa, pb, da, db;
  logic     st_c, up_c, bad_c;

  assign fn = qc_func_e'(func);
  assign da = a ^ pa;
  assign db = b ^ pb;

  always_comb begin
    st_c  = 1'b0;
    up_c  = 1'b0;
    bad_c = 1'b0;
    if (fn == FN_PULSE_DIR) begin
      if (a && !pa) begin
        st_c = 1'b1;
        up_c = b;
      end
    end else if (da && db) begin
      bad_c = 1'b1;
    end else if (da) begin
      if (fn == FN_QX1) begin
        if (!b) begin
          st_c = 1'b1;
          up_c = a;
        end
      end else begin
        st_c = 1'b1;
        up_c = a ^ b;
      end
    end else if (db && fn == FN_QX4) begin
      st_c = 1'b1;
      up_c = ~(a ^ b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pa      <= 1'b0;
      pb      <= 1'b0;
      step    <= 1'b0;
      up      <= 1'b0;
      illegal <= 1'b0;
    end else begin
      pa      <= a;
      pb      <= b;
      step    <= st_c;
      up      <= up_c;
      illegal <= bad_c;
    end
  end
endmodule

// File: rtl/qc_count_unit.sv
// Count register with limit policies, wrap toggles and status flags.
module qc_count_unit
  import qc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       limit,
  input  logic [CNT_W-1:0] ceiling,
  input  logic             en,
  input  logic             step,
  input  logic             up,
  input  logic             illegal,
  input  logic             clear,
  input  logic             load,
  input  logic             idx_load,
  input  logic             flag_clear,
  output logic [CNT_W-1:0] count,
  output logic             borrow,
  output logic             carry,
  output logic             up_flag,
  output logic             noise
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  qc_limit_e lm;
  logic      frozen;
  logic      ceil_mode;
  logic      take;

  assign lm        = qc_limit_e'(limit);
  assign ceil_mode = (lm == LM_CLAMP) || (lm == LM_MODULO);
  assign take      = step && en && !(frozen && lm == LM_ONESHOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      borrow  <= 1'b0;
      carry   <= 1'b0;
      up_flag <= 1'b0;
      noise   <= 1'b0;
      frozen  <= 1'b0;
    end else begin
      if (flag_clear) begin
        borrow <= 1'b0;
        carry  <= 1'b0;
        noise  <= 1'b0;
      end
      if (illegal) noise <= 1'b1;
      if (lm != LM_ONESHOT) frozen <= 1'b0;

      if (clear) begin
        count  <= '0;
        frozen <= 1'b0;
      end else if (load || idx_load) begin
        count  <= ceiling;
        frozen <= 1'b0;
      end else if (take) begin
        up_flag <= up;
        if (up) begin
          if (ceil_mode && count >= ceiling) begin
            if (lm == LM_MODULO) begin
              count <= '0;
              carry <= ~carry;
            end
          end else if (count == TOP) begin
            count <= '0;
            carry <= ~carry;
            if (lm == LM_ONESHOT) frozen <= 1'b1;
          end else begin
            count <= count + 1'b1;
          end
        end else begin
          if (count == '0) begin
            if (lm == LM_MODULO) begin
              count  <= ceiling;
              borrow <= ~borrow;
            end else if (lm != LM_CLAMP) begin
              count  <= TOP;
              borrow <= ~borrow;
              if (lm == LM_ONESHOT) frozen <= 1'b1;
            end
          end else begin
            count <= count - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/quad_count_core.sv
module quad_count_core
  import qc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       func_sel,
  input  logic [1:0]       limit_mode,
  input  logic [CNT_W-1:0] preset,
  input  logic             count_en,
  input  logic             load_strobe,
  input  logic             clear_strobe,
  input  logic             flag_clear,
  input  logic             idx_preset_en,
  input  logic             idx_pol,
  input  logic             idx_sync_req,
  input  logic [DIV_W-1:0] filt_div,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_idx,
  output logic [CNT_W-1:0] count,
  output logic             borrow_tog,
  output logic             carry_tog,
  output logic             up_flag,
  output logic             noise_err,
  output logic             idx_sync
);
  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] clean;
  logic              fa, fb, fi, pi;
  logic              step, up, illegal;
  logic              idx_edge, idx_load;

  qc_deglitch #(.NUM(NUM_IN), .DIV_W(DIV_W)) u_filt (
    .clk   (clk),
    .rst   (rst),
    .div   (filt_div),
    .raw   ({in_idx, in_b, in_a}),
    .clean (clean)
  );

  assign fa = clean[0];
  assign fb = clean[1];
  assign fi = clean[2];

  qc_edge_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .func    (func_sel),
    .a       (fa),
    .b       (fb),
    .step    (step),
    .up      (up),
    .illegal (illegal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pi       <= 1'b0;
      idx_sync <= 1'b0;
    end else begin
      pi       <= fi;
      idx_sync <= idx_sync_req && (qc_func_e'(func_sel) != FN_PULSE_DIR);
    end
  end

  assign idx_edge = idx_pol ? (fi && !pi) : (!fi && pi);
  assign idx_load = idx_preset_en && idx_edge && (!idx_sync || (!fa && !fb));

  qc_count_unit #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .limit      (limit_mode),
    .ceiling    (preset),
    .en         (count_en),
    .step       (step),
    .up         (up),
    .illegal    (illegal),
    .clear      (clear_strobe),
    .load       (load_strobe),
    .idx_load   (idx_load),
    .flag_clear (flag_clear),
    .count      (count),
    .borrow     (borrow_tog),
    .carry      (carry_tog),
    .up_flag    (up_flag),
    .noise      (noise_err)
  );
endmodule

// File: rtl/quad_count_core_chk.sv
module quad_count_core_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       func_sel,
  input logic [1:0]       limit_mode,
  input logic [CNT_W-1:0] preset,
  input logic             count_en,
  input logic             load_strobe,
  input logic             clear_strobe,
  input logic             flag_clear,
  input logic             idx_preset_en,
  input logic [CNT_W-1:0] count,
  input logic             borrow_tog,
  input logic             carry_tog,
  input logic             noise_err,
  input logic             up_flag,
  input logic             idx_sync
);
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (rst)
    $past(clear_strobe) |-> count == '0);

  p_load_preset_r10: assert property (@(posedge clk) disable iff (rst)
    $past(load_strobe && !clear_strobe) |-> count == $past(preset));

  p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(flag_clear) |-> (!borrow_tog && !carry_tog));

  p_hold_disabled_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!count_en && !clear_strobe && !load_strobe && !idx_preset_en)
      |-> ($stable(count) && $stable(up_flag)));

  p_sync_quad_r13: assert property (@(posedge clk) disable iff (rst)
    idx_sync |-> $past(func_sel) != 2'd0);

  p_clamp_ceiling_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(limit_mode == 2'd1) && limit_mode == 2'd1 && $stable(preset)
     && $past(count <= preset)
     && $past(!load_strobe && !clear_strobe && !idx_preset_en))
      |-> count <= preset);

  p_clamp_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(limit_mode == 2'd1) && $past(!flag_clear))
      |-> ($stable(borrow_tog) && $stable(carry_tog)));
endmodule

bind quad_count_core quad_count_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .func_sel      (func_sel),
  .limit_mode    (limit_mode),
  .preset        (preset),
  .count_en      (count_en),
  .load_strobe   (load_strobe),
  .clear_strobe  (clear_strobe),
  .flag_clear    (flag_clear),
  .idx_preset_en (idx_preset_en),
  .count         (count),
  .borrow_tog    (borrow_tog),
  .carry_tog     (carry_tog),
  .noise_err     (noise_err),
  .up_flag       (up_flag),
  .idx_sync      (idx_sync)
);

// File: tb/quad_count_core_test.sv
module quad_count_core_test;
  localparam int W = 24;
  localparam logic [W-1:0] TOPV = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   func_sel = 2'd0;
  logic [1:0]   limit_mode = 2'd0;
  logic [W-1:0] preset = '0;
  logic         count_en = 1'b0;
  logic         load_strobe = 1'b0;
  logic         clear_strobe = 1'b0;
  logic         flag_clear = 1'b0;
  logic         idx_preset_en = 1'b0;
  logic         idx_pol = 1'b1;
  logic         idx_sync_req = 1'b0;
  logic [7:0]   filt_div = 8'd1;
  logic         in_a = 1'b0;
  logic         in_b = 1'b0;
  logic         in_idx = 1'b0;
  logic [W-1:0] count;
  logic         borrow_tog, carry_tog, up_flag, noise_err, idx_sync;

  quad_count_core uut (
    .clk(clk), .rst(rst), .func_sel(func_sel), .limit_mode(limit_mode),
    .preset(preset), .count_en(count_en), .load_strobe(load_strobe),
    .clear_strobe(clear_strobe), .flag_clear(flag_clear),
    .idx_preset_en(idx_preset_en), .idx_pol(idx_pol),
    .idx_sync_req(idx_sync_req), .filt_div(filt_div), .in_a(in_a),
    .in_b(in_b), .in_idx(in_idx), .count(count), .borrow_tog(borrow_tog),
    .carry_tog(carry_tog), .up_flag(up_flag), .noise_err(noise_err),
    .idx_sync(idx_sync)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // bench model state
  logic [W-1:0] m_cnt = '0;
  logic m_bor = 0, m_car = 0, m_up = 0, m_noise = 0, m_frz = 0;
  logic pa = 0, pb = 0, pidx = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "count", 32'(count), 32'(m_cnt));
    check(req, "borrow", 32'(borrow_tog), 32'(m_bor));
    check(req, "carry", 32'(carry_tog), 32'(m_car));
    check(req, "up_flag", 32'(up_flag), 32'(m_up));
    check(req, "noise", 32'(noise_err), 32'(m_noise));
    check("R13", "idx_sync", 32'(idx_sync),
          32'(idx_sync_req && func_sel != 2'd0));
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle();
    cycles(4 * (int'(filt_div) + 1) + 12);
  endtask

  task automatic apply_step(input logic u);
    if (!count_en || (m_frz && limit_mode == 2'd2)) return;
    m_up = u;
    if (u) begin
      if ((limit_mode == 2'd1 || limit_mode == 2'd3) && m_cnt >= preset) begin
        if (limit_mode == 2'd3) begin m_cnt = '0; m_car = ~m_car; end
      end else if (m_cnt == TOPV) begin
        m_cnt = '0; m_car = ~m_car;
        if (limit_mode == 2'd2) m_frz = 1'b1;
      end else m_cnt = m_cnt + 1'b1;
    end else begin
      if (m_cnt == '0) begin
        if (limit_mode == 2'd3) begin m_cnt = preset; m_bor = ~m_bor; end
        else if (limit_mode != 2'd1) begin
          m_cnt = TOPV; m_bor = ~m_bor;
          if (limit_mode == 2'd2) m_frz = 1'b1;
        end
      end else m_cnt = m_cnt - 1'b1;
    end
  endtask

  // drive new phase levels, let them through, update model, check
  task automatic drive_ab(input logic na, input logic nb, input string req);
    logic da, db;
    in_a = na; in_b = nb;
    settle();
    da = na ^ pa; db = nb ^ pb;
    if (func_sel == 2'd0) begin
      if (na && !pa) apply_step(nb);
    end else if (da && db) m_noise = 1'b1;
    else if (da) begin
      if (func_sel == 2'd1) begin
        if (!nb) apply_step(na);
      end else apply_step(na ^ nb);
    end else if (db && func_sel == 2'd3) apply_step(~(na ^ nb));
    pa = na; pb = nb;
    check_all(req);
  endtask

  // one gray-code move forward or backward (x4 counts each move)
  task automatic move(input logic fwd, input string req);
    int p;
    p = (!pa && !pb) ? 0 : (pa && !pb) ? 1 : (pa && pb) ? 2 : 3;
    p = fwd ? (p + 1) % 4 : (p + 3) % 4;
    case (p)
      0: drive_ab(1'b0, 1'b0, req);
      1: drive_ab(1'b1, 1'b0, req);
      2: drive_ab(1'b1, 1'b1, req);
      default: drive_ab(1'b0, 1'b1, req);
    endcase
  endtask

  task automatic rand_walk(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(1, 0) == 1) drive_ab(~pa, pb, req);
      else drive_ab(pa, ~pb, req);
    end
  endtask

  task automatic pulse_clear();
    clear_strobe = 1'b1; @(negedge clk); clear_strobe = 1'b0;
    cycles(2); m_cnt = '0; m_frz = 1'b0;
  endtask

  task automatic pulse_load();
    load_strobe = 1'b1; @(negedge clk); load_strobe = 1'b0;
    cycles(2); m_cnt = preset; m_frz = 1'b0;
  endtask

  task automatic pulse_flags();
    flag_clear = 1'b1; @(negedge clk); flag_clear = 1'b0;
    cycles(2); m_bor = 0; m_car = 0; m_noise = 0;
  endtask

  task automatic set_limit(input logic [1:0] lm);
    limit_mode = lm; m_frz = 1'b0; cycles(2);
  endtask

  task automatic drive_idx(input logic v, input string req);
    logic edge_ok;
    in_idx = v;
    settle();
    edge_ok = idx_pol ? (v && !pidx) : (!v && pidx);
    if (idx_preset_en && edge_ok &&
        (!(idx_sync_req && func_sel != 2'd0) || (!pa && !pb))) begin
      m_cnt = preset; m_frz = 1'b0;
    end
    pidx = v;
    check_all(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cycles(5);
    rst = 1'b0;
    cycles(3);
    check_all("R1");
    count_en = 1'b1;

    // pulse/direction
    func_sel = 2'd0; cycles(2);
    rand_walk(40, "R2");
    drive_ab(1'b0, 1'b1, "R2"); drive_ab(1'b1, 1'b1, "R2");
    drive_ab(1'b0, 1'b1, "R2"); drive_ab(1'b0, 1'b0, "R2");

    // quadrature decoders
    for (int f = 1; f <= 3; f++) begin
      func_sel = 2'(f); filt_div = 8'($urandom_range(3, 0));
      pulse_clear(); check_all("R10");
      rand_walk(40, "R3");
      for (int k = 0; k < 4; k++) move(1'b1, "R3");
      for (int k = 0; k < 4; k++) move(1'b0, "R9");
    end

    // illegal transitions
    func_sel = 2'd3; cycles(2);
    drive_ab(~pa, ~pb, "R4");
    check("R4", "noise set", 32'(noise_err), 32'd1);
    pulse_flags(); check_all("R10");
    func_sel = 2'd0; cycles(2);
    drive_ab(~pa, ~pb, "R4"); drive_ab(~pa, ~pb, "R4");
    check("R4", "no noise in pulse mode", 32'(noise_err), 32'd0);

    // free-running wrap
    func_sel = 2'd3; set_limit(2'd0); pulse_clear(); pulse_flags();
    move(1'b0, "R5");
    check("R5", "underflow wrap", 32'(count), 32'hFFFFFF);
    preset = 24'hFFFFFE; pulse_load();
    for (int k = 0; k < 3; k++) move(1'b1, "R5");
    check("R5", "carry toggled", 32'(carry_tog), 32'd1);

    // clamp
    pulse_flags(); preset = 24'd5; set_limit(2'd1); pulse_clear();
    for (int k = 0; k < 8; k++) move(1'b1, "R6");
    check("R6", "held at ceiling", 32'(count), 32'd5);
    for (int k = 0; k < 8; k++) move(1'b0, "R6");
    check("R6", "held at zero", 32'(count), 32'd0);

    // one-shot
    preset = 24'd2; set_limit(2'd2); pulse_load();
    for (int k = 0; k < 5; k++) move(1'b0, "R7");
    check("R7", "frozen after wrap", 32'(count), 32'hFFFFFF);
    pulse_load(); check_all("R10");
    move(1'b0, "R7");
    check("R7", "counting after load", 32'(count), 32'd1);

    // modulo
    pulse_flags(); preset = 24'd4; set_limit(2'd3); pulse_clear();
    for (int k = 0; k < 7; k++) move(1'b1, "R8");
    check("R8", "modulo up", 32'(count), 32'd2);
    for (int k = 0; k < 4; k++) move(1'b0, "R8");
    check("R8", "modulo down", 32'(count), 32'd3);

    // clear over load
    preset = 24'h00ABCD;
    clear_strobe = 1'b1; load_strobe = 1'b1; @(negedge clk);
    clear_strobe = 1'b0; load_strobe = 1'b0; cycles(2);
    m_cnt = '0; m_frz = 1'b0;
    check("R10", "clear beats load", 32'(count), 32'd0);

    // random mix across functions and policies
    for (int r = 0; r < 12; r++) begin
      func_sel = 2'($urandom_range(3, 0));
      set_limit(2'($urandom_range(3, 0)));
      preset = 24'($urandom_range(9, 1));
      filt_div = 8'($urandom_range(3, 0));
      if ($urandom_range(1, 0) == 1) pulse_load();
      rand_walk(15, "R3");
    end

    // enable gate
    count_en = 1'b0; cycles(2);
    rand_walk(6, "R11");
    count_en = 1'b1; cycles(2);

    // index loads
    func_sel = 2'd3; set_limit(2'd0); preset = 24'h123456;
    pulse_clear(); idx_preset_en = 1'b0; idx_pol = 1'b1;
    drive_idx(1'b1, "R12"); drive_idx(1'b0, "R12");
    check("R12", "disabled index", 32'(count), 32'd0);
    idx_preset_en = 1'b1;
    drive_idx(1'b1, "R12");
    check("R12", "rising load", 32'(count), 32'h123456);
    pulse_clear(); drive_idx(1'b0, "R12");
    check("R12", "falling ignored", 32'(count), 32'd0);
    idx_pol = 1'b0; drive_idx(1'b1, "R12"); drive_idx(1'b0, "R12");
    check("R12", "falling load", 32'(count), 32'h123456);

    // synchronous index qualification
    if (pa || pb) drive_ab(1'b0, 1'b0, "R13");
    idx_pol = 1'b1; idx_sync_req = 1'b1; cycles(2);
    pulse_clear(); move(1'b1, "R13");
    drive_idx(1'b1, "R13"); drive_idx(1'b0, "R13");
    check("R13", "gated off phases", 32'(count), 32'd1);
    move(1'b0, "R13");
    drive_idx(1'b1, "R13"); drive_idx(1'b0, "R13");
    check("R13", "load with phases low", 32'(count), 32'h123456);
    func_sel = 2'd0; cycles(2); pulse_clear();
    drive_ab(1'b1, 1'b0, "R13");
    drive_idx(1'b1, "R13");
    check("R13", "pulse mode not synchronous", 32'(idx_sync), 32'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    cycles(190000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule